// File: doc/BRIEF.md
# Timer Count-Tick Source Selector

This block sits in front of a timer counter and tells it when to count. A 2-bit select input chooses one of four sources. Three of them are divided copies of the system clock, all taken from one shared free-running prescaler. The fourth is an external pin. The block produces `count_tick`, a pulse one system clock wide. The counter adds one on every cycle in which that pulse is high.

For the divided sources, a tick is made when the chosen divided clock goes from high to low. The external pin first passes through a two-stage synchronizer, and a tick is made on its rising edge. Edge detection looks at the output of the source multiplexer, not at each source on its own. Because of this, changing the select code while the old source is high and the new one is low produces one extra tick. Switching between the internal and external groups can also produce a spurious tick. The counter and any register decoding beyond the select input belong to other blocks.

Top module: `tick_src_sel`

## Requirements
- R1: With select code 00 (divide by 4), consecutive ticks are exactly 4 system clock cycles apart.
- R2: With select code 01 (divide by 8), consecutive ticks are exactly 8 cycles apart.
- R3: With select code 10 (divide by 32), consecutive ticks are exactly 32 cycles apart, and each tick is preceded by a fall of the divide-by-8 tap.
- R4: With select code 11 (external), a rising edge on `ext_clk_in` gives a tick on the third rising clock edge after the input rises, and a falling edge gives none.
- R5: While `rst_n` is low, `count_tick` is low and the prescaler is cleared. With code 00 (the reset default code), the first tick is registered at the fifth rising edge after reset is released.
- R6: Every tick lasts exactly one clock cycle.
- R7: External high and low phases of at least 2 clock cycles each (above the 1.5-period minimum) are each counted exactly once per rising edge.
- R8: Changing the select code while the old source level is high and the new level is low gives one extra tick at the first clock edge after the change.
- R9: Changing the select code low-to-low, low-to-high or high-to-high gives no extra tick. The next tick comes from the new source's own falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 2 | Source code: 00 div 4, 01 div 8, 10 div 32, 11 external |
| ext_clk_in | input | 1 | Asynchronous external count input |
| count_tick | output | 1 | One-cycle count-enable pulse |

## Verification
The hardest cases to reach are the switch cases, because the prescaler phase is hidden inside the block. The bench recovers the phase from the ports. It selects divide-by-32 and waits for a tick, which fixes the prescaler count at 1 modulo 32. It then waits a known number of cycles and changes the select code. This places the old and new source levels in exactly the high/low combination each switch case needs. External edges are driven on falling clock edges, so the three-register latency is exact.

// File: rtl/tss_pkg.sv
// Shared types and constants for the tick source selector.
// Assumes a 2-bit select code and nothing else.
package tss_pkg;
    typedef enum logic [1:0] {
        SRC_DIV_A = 2'b00,
        SRC_DIV_B = 2'b01,
        SRC_DIV_C = 2'b10,
        SRC_EXT   = 2'b11
    } tss_src_e;

    localparam tss_src_e SRC_RESET_DEFAULT = SRC_DIV_A;
endpackage

// File: rtl/tss_prescaler.sv
// Free-running binary prescaler shared by all internal sources.
// Tap k is bit (LOGk-1) of the count, a 50% clock of period 2**LOGk.
// Assumes LOG_A < LOG_B < LOG_C.
module tss_prescaler #(
    parameter int LOG_A = 2,
    parameter int LOG_B = 3,
    parameter int LOG_C = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic tap_a,
    output logic tap_b,
    output logic tap_c
);
    localparam int CW = LOG_C;

    logic [CW-1:0] cnt_q;

    // Count every cycle; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign tap_a = cnt_q[LOG_A-1];
    assign tap_b = cnt_q[LOG_B-1];
    assign tap_c = cnt_q[LOG_C-1];
endmodule

// File: rtl/tss_sync.sv
// Multi-stage synchronizer for the asynchronous external input.
// Assumes STAGES >= 2; output is the last stage.
module tss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] sh_q;

    // Shift the input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_async};
    end

    assign q_sync = sh_q[STAGES-1];
endmodule

// File: rtl/tss_fall_det.sv
// Registered high-to-low detector on a single level.
// Output pulse is one cycle wide and registered.
module tss_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall_pulse
);
    logic prev_q;

    // Remember last level and register the falling-edge decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= 1'b0;
            fall_pulse <= 1'b0;
        end else begin
            prev_q     <= lvl;
            fall_pulse <= prev_q & ~lvl;
        end
    end
endmodule

// File: rtl/tick_src_sel.sv
// Top: picks a count source and emits a one-cycle tick per counted edge.
// Internal sources count on falling edges; the external input is inverted
// after synchronization so its rising edge becomes a fall at the mux.
// Edge detection sits after the mux, so a select change can add a tick.
module tick_src_sel #(
    parameter int LOG_A       = 2,
    parameter int LOG_B       = 3,
    parameter int LOG_C       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       ext_clk_in,
    output logic       count_tick
);
    import tss_pkg::*;

    logic tap_a, tap_b, tap_c;
    logic ext_lvl;
    logic mux_lvl;
    tss_src_e src;

    tss_prescaler #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .tap_a(tap_a), .tap_b(tap_b), .tap_c(tap_c)
    );

    tss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ext_clk_in), .q_sync(ext_lvl)
    );

    assign src = tss_src_e'(sel);

    // Select the level whose falling edge counts.
    always_comb begin
        unique case (src)
            SRC_DIV_A: mux_lvl = tap_a;
            SRC_DIV_B: mux_lvl = tap_b;
            SRC_DIV_C: mux_lvl = tap_c;
            default:   mux_lvl = ~ext_lvl;
        endcase
    end

    tss_fall_det u_det (
        .clk(clk), .rst_n(rst_n), .lvl(mux_lvl), .fall_pulse(count_tick)
    );
endmodule

// File: rtl/tick_src_sel_chk.sv
// Checker for tick_src_sel, bound to every instance of it.
module tick_src_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel,
    input logic       tap_a,
    input logic       tap_b,
    input logic       tap_c,
    input logic       ext_lvl,
    input logic       tick
);
    // R5
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !tick);

    // R6
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R1
    div_a_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && $past(sel) == 2'b00 && $past(tap_a, 2) && !$past(tap_a)) |-> tick);

    // R3
    div_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tap_c) |-> $fell(tap_b));

    // R4
    ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == 2'b11 && $past(sel) == 2'b11 && $past(sel, 2) == 2'b11)
        |-> ($past(ext_lvl) && !$past(ext_lvl, 2)));
endmodule

bind tick_src_sel tick_src_sel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .tap_a(tap_a), .tap_b(tap_b), .tap_c(tap_c),
    .ext_lvl(ext_lvl), .tick(count_tick)
);

// File: tb/tick_src_sel_bench.sv
module tick_src_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       ext_clk_in = 1'b0;
    logic       count_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tick_src_sel u_tick_src_sel (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .ext_clk_in(ext_clk_in), .count_tick(count_tick)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Steps until tick is seen; returns step count (or limit+1).
    task automatic wait_tick(input int limit, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!count_tick && n <= limit);
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0; sel = 2'b00;
        repeat (4) step();
        check(count_tick == 1'b0, "R5 tick low in reset", count_tick, 0);
        rst_n = 1'b1;
        wait_tick(20, n);
        check(n == 5, "R5 first div4 tick edge", n, 5);
    endtask

    task automatic t_period(input logic [1:0] code, input int per, input string tag);
        int n;
        sel = code;
        wait_tick(80, n);
        wait_tick(80, n);
        for (int i = 0; i < 2; i++) begin
            step();
            check(count_tick == 1'b0, "R6 one-cycle tick", count_tick, 0);
            n = 1;
            while (!count_tick && n <= 80) begin step(); n++; end
            check(n == per, tag, n, per);
        end
    endtask

    // Align prescaler to count 1 mod 32 using a div-32 tick.
    task automatic align();
        int n;
        sel = 2'b10;
        repeat (40) step();
        wait_tick(40, n);
    endtask

    // After align, wait w steps, switch to div4, expect first tick after e steps.
    task automatic t_switch(input int w, input int e, input string tag);
        int n;
        align();
        repeat (w) step();
        sel = 2'b00;
        wait_tick(10, n);
        check(n == e, tag, n, e);
    endtask

    task automatic t_ext_edges();
        int n;
        ext_clk_in = 1'b0;
        sel = 2'b11;
        repeat (6) step();
        ext_clk_in = 1'b1;
        wait_tick(10, n);
        check(n == 3, "R4 rise latency", n, 3);
        repeat (4) step();
        ext_clk_in = 1'b0;
        n = 0;
        for (int i = 0; i < 8; i++) begin step(); if (count_tick) n++; end
        check(n == 0, "R4 fall not counted", n, 0);
    endtask

    task automatic t_ext_min_pulse();
        int n = 0;
        sel = 2'b11; ext_clk_in = 1'b0;
        repeat (4) step();
        for (int i = 0; i < 5; i++) begin
            ext_clk_in = 1'b1;
            step(); if (count_tick) n++;
            step(); if (count_tick) n++;
            ext_clk_in = 1'b0;
            step(); if (count_tick) n++;
            step(); if (count_tick) n++;
        end
        for (int i = 0; i < 6; i++) begin step(); if (count_tick) n++; end
        check(n == 5, "R7 two-cycle pulses counted once", n, 5);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin @(posedge clk); wd++; end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_period(2'b00, 4,  "R1 div4 spacing");
        t_period(2'b01, 8,  "R2 div8 spacing");
        t_period(2'b10, 32, "R3 div32 spacing");
        // old div32 high, new div4 low: extra tick next edge
        t_switch(16, 1, "R8 high-to-low extra tick");
        // low-to-low: next natural div4 fall
        t_switch(0, 4, "R9 low-to-low no extra");
        // low-to-high
        t_switch(1, 3, "R9 low-to-high no extra");
        // high-to-high
        t_switch(17, 3, "R9 high-to-high no extra");
        t_ext_edges();
        t_ext_min_pulse();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule